// File: doc/BRIEF.md
# Weighted Round-Robin Queue Sequencer

This block decides which of four egress queues a transmitter serves next. Service order comes from a programmable table of queue numbers. A pointer walks the table. Each queue's share of the link is therefore set by how often its number appears in the active part of the table. Queue 3 is the most urgent class and queue 0 the least, and the reset pattern reflects this by naming queue 3 in every other slot.

Software loads the table through a 16-bit command word that fills four consecutive slots at a time. A busy flag paces these writes. A separate length value selects how many slots, counted from slot 0, take part in the rotation. Each cycle the block looks at the current slot. If the queue named there has nothing to send, the block moves on to later slots in the same cycle, wrapping at the end of the active part. It presents the first slot whose queue holds data. The pointer moves past that slot only when the transmitter takes the grant.

Top module: `wrr_queue_sequencer`

## Requirements
- R1: After reset the active length is 15, the busy flag is 0, the pointer is at slot 0, and slots 0..14 hold the queue pattern 3,2,3,1,3,2,3,0,3,2,3,1,3,2,3. With every queue non-empty and a grant every cycle, that pattern is presented and then repeats.
- R2: A command word is accepted only when bit 15 is 1. Bits 12:8 give a group number g. Bits 1:0, 3:2, 5:4 and 7:6 land in slots 4g, 4g+1, 4g+2 and 4g+3 respectively. A word with bit 15 clear changes no slot and does not move the pointer.
- R3: The busy flag reads 1 during the cycle after a command word is accepted and 0 in the cycle after that. A command word presented while busy reads 1 is ignored.
- R4: A length write with a value from 1 to 128 sets the active length. Any other value is ignored. After the last active slot, the pointer continues at slot 0.
- R5: If the queue named by the slot under the pointer is empty, the block presents, in the same cycle, the first later active slot (wrapping to slot 0) whose queue is non-empty. A valid selection always names a non-empty queue.
- R6: When no active slot names a non-empty queue, the valid output is 0.
- R7: The pointer moves only in a cycle where grant request and valid are both 1. It then moves to the slot after the presented slot.
- R8: An accepted command word or length write returns the pointer to slot 0. This takes precedence over a grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_nonempty | input | 4 | Bit i is 1 when queue i holds a packet |
| grant_req | input | 1 | Transmitter takes the presented queue this cycle |
| tbl_wr_en | input | 1 | Strobe for a table command word |
| tbl_wr_word | input | 16 | Table command word (flag, group, four slot values) |
| len_wr_en | input | 1 | Strobe for a length write |
| len_wr_val | input | 8 | New active length |
| tbl_busy | output | 1 | Table write in progress; software waits for 0 |
| sel_queue | output | 2 | Queue number presented for service |
| sel_valid | output | 1 | A queue is presented |

## Verification
On every cycle, the embedded properties check four things. A valid choice names a queue that holds data. An all-empty input gives no choice. Busy never lasts two cycles. The pointer stays below the active length, holds when nothing is granted, and returns to slot 0 after an accepted write.

Only the bench's scenarios can show the cases that depend on table contents and ordering. These are the exact reset pattern, the slot placement of each field in a command word, skipping across a wrap, the use of slot 127 at full length, and the fact that rejected writes leave both the table and the pointer untouched.

// File: rtl/wrr_seq_pkg.sv
package wrr_seq_pkg;
   localparam int WORD_W   = 16;   // command word width
   localparam int FLAG_BIT = 15;   // update / busy flag position
   localparam int GRP_LSB  = 8;    // lowest bit of the group number
   localparam int DATA_W   = 8;    // slot payload bits per word
   localparam int DFLT_LEN = 15;   // slots active after reset

   // Reset content of a slot: top class every other slot, then halving shares.
   function automatic logic [1:0] dflt_slot(input int p);
      if (p >= DFLT_LEN)  return 2'd0;
      if (p % 2 == 0)     return 2'd3;
      if (p % 4 == 1)     return 2'd2;
      if (p % 8 == 3)     return 2'd1;
      return 2'd0;
   endfunction
endpackage

// File: rtl/wrr_seq_table.sv
module wrr_seq_table
   import wrr_seq_pkg::*;
#(
   parameter int MAX_ENT = 128,
   parameter int QW      = 2,
   parameter int LEN_W   = $clog2(MAX_ENT + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [WORD_W-1:0]            wr_word,
   input  logic                         len_wr_en,
   input  logic [LEN_W-1:0]             len_wr_val,
   output logic [MAX_ENT-1:0][QW-1:0]   tbl,
   output logic [LEN_W-1:0]             len,
   output logic                         busy,
   output logic                         tbl_accept,
   output logic                         len_accept
);
   localparam int EPW    = DATA_W / QW;
   localparam int NGRP   = MAX_ENT / EPW;
   localparam int GIDX_W = $clog2(NGRP);

   if (MAX_ENT % EPW != 0) begin : g_bad_depth
      $error("MAX_ENT must be a multiple of the slots per word");
   end
   if (MAX_ENT < 2 * DFLT_LEN) begin : g_bad_min
      $error("MAX_ENT too small for the reset pattern");
   end
   if (GRP_LSB + GIDX_W > FLAG_BIT) begin : g_bad_grp
      $error("group field overlaps the flag bit");
   end

   logic [GIDX_W-1:0] grp;
   assign grp        = wr_word[GRP_LSB +: GIDX_W];
   assign tbl_accept = wr_en && wr_word[FLAG_BIT] && !busy;
   assign len_accept = len_wr_en && (len_wr_val != '0) &&
                       (len_wr_val <= LEN_W'(MAX_ENT));

   for (genvar e = 0; e < MAX_ENT; e++) begin : g_slot
      localparam int G = e / EPW;
      localparam int K = e % EPW;
      logic [QW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q <= QW'(dflt_slot(e));
         else if (tbl_accept && (grp == GIDX_W'(G)))
            slot_q <= wr_word[K*QW +: QW];
      end
      assign tbl[e] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          busy <= 1'b0;
      else if (busy)       busy <= 1'b0;
      else if (tbl_accept) busy <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          len <= LEN_W'(DFLT_LEN);
      else if (len_accept) len <= len_wr_val;
   end

   AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);                                          // R3
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (len != '0) && (len <= LEN_W'(MAX_ENT)));                 // R4
endmodule

// File: rtl/wrr_seq_pick.sv
module wrr_seq_pick #(
   parameter int NUM_Q   = 4,
   parameter int MAX_ENT = 128,
   parameter int QW      = 2,
   parameter int LEN_W   = 8,
   parameter int PTR_W   = 7
) (
   input  logic [MAX_ENT-1:0][QW-1:0] tbl,
   input  logic [LEN_W-1:0]           len,
   input  logic [PTR_W-1:0]           ptr,
   input  logic [NUM_Q-1:0]           q_nonempty,
   output logic                       hit,
   output logic [PTR_W-1:0]           hit_idx
);
   logic [MAX_ENT-1:0] elig, upper, lower;

   for (genvar j = 0; j < MAX_ENT; j++) begin : g_elig
      assign elig[j]  = q_nonempty[tbl[j]] && (LEN_W'(j) < len);
      assign upper[j] = elig[j] && (PTR_W'(j) >= ptr);
   end
   assign lower = elig & ~upper;

   logic             up_hit, lo_hit;
   logic [PTR_W-1:0] up_idx, lo_idx;

   always_comb begin
      up_hit = 1'b0;
      up_idx = '0;
      lo_hit = 1'b0;
      lo_idx = '0;
      for (int j = MAX_ENT - 1; j >= 0; j--) begin
         if (upper[j]) begin
            up_hit = 1'b1;
            up_idx = PTR_W'(j);
         end
         if (lower[j]) begin
            lo_hit = 1'b1;
            lo_idx = PTR_W'(j);
         end
      end
   end

   assign hit     = up_hit || lo_hit;
   assign hit_idx = up_hit ? up_idx : lo_idx;
endmodule

// File: rtl/wrr_seq_ptr.sv
module wrr_seq_ptr #(
   parameter int LEN_W = 8,
   parameter int PTR_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic [PTR_W-1:0] hit_idx,
   input  logic [LEN_W-1:0] len,
   input  logic             clear,
   output logic [PTR_W-1:0] ptr
);
   logic [PTR_W-1:0] nxt;
   assign nxt = (LEN_W'(hit_idx) == len - LEN_W'(1)) ? '0 : hit_idx + PTR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr <= '0;
      else if (clear)   ptr <= '0;
      else if (advance) ptr <= nxt;
   end

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !clear) |=> $stable(ptr));                   // R7
   AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ptr == '0));                                   // R8
   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      LEN_W'(ptr) < len);                                       // R4
endmodule

// File: rtl/wrr_queue_sequencer.sv
module wrr_queue_sequencer
   import wrr_seq_pkg::*;
#(
   parameter int NUM_Q   = 4,
   parameter int MAX_ENT = 128,
   parameter int QW      = $clog2(NUM_Q),
   parameter int LEN_W   = $clog2(MAX_ENT + 1),
   parameter int PTR_W   = $clog2(MAX_ENT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_Q-1:0]   q_nonempty,
   input  logic               grant_req,
   input  logic               tbl_wr_en,
   input  logic [WORD_W-1:0]  tbl_wr_word,
   input  logic               len_wr_en,
   input  logic [LEN_W-1:0]   len_wr_val,
   output logic               tbl_busy,
   output logic [QW-1:0]      sel_queue,
   output logic               sel_valid
);
   if (NUM_Q != 4) begin : g_bad_q
      $error("the reset pattern needs exactly four queues");
   end

   logic [MAX_ENT-1:0][QW-1:0] tbl;
   logic [LEN_W-1:0]           len;
   logic [PTR_W-1:0]           ptr, hit_idx;
   logic                       hit, tbl_accept, len_accept;

   wrr_seq_table #(.MAX_ENT(MAX_ENT), .QW(QW), .LEN_W(LEN_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_wr_en), .wr_word(tbl_wr_word),
      .len_wr_en(len_wr_en), .len_wr_val(len_wr_val),
      .tbl(tbl), .len(len), .busy(tbl_busy),
      .tbl_accept(tbl_accept), .len_accept(len_accept)
   );

   wrr_seq_pick #(.NUM_Q(NUM_Q), .MAX_ENT(MAX_ENT), .QW(QW),
                  .LEN_W(LEN_W), .PTR_W(PTR_W)) u_pick (
      .tbl(tbl), .len(len), .ptr(ptr), .q_nonempty(q_nonempty),
      .hit(hit), .hit_idx(hit_idx)
   );

   wrr_seq_ptr #(.LEN_W(LEN_W), .PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .advance(grant_req && hit), .hit_idx(hit_idx), .len(len),
      .clear(tbl_accept || len_accept), .ptr(ptr)
   );

   assign sel_valid = hit;
   assign sel_queue = hit ? tbl[hit_idx] : '0;

   AST_SEL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> q_nonempty[sel_queue]);                     // R5
   AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (q_nonempty == '0) |-> !sel_valid);                       // R6
endmodule

// File: tb/sim_wrr_queue_sequencer.sv
`timescale 1ns/1ps
module sim_wrr_queue_sequencer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] q_nonempty = '0;
   logic       grant_req = 1'b0;
   logic       tbl_wr_en = 1'b0;
   logic [15:0] tbl_wr_word = '0;
   logic       len_wr_en = 1'b0;
   logic [7:0] len_wr_val = '0;
   logic       tbl_busy;
   logic [1:0] sel_queue;
   logic       sel_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wrr_queue_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .grant_req(grant_req),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_word(tbl_wr_word),
      .len_wr_en(len_wr_en), .len_wr_val(len_wr_val),
      .tbl_busy(tbl_busy), .sel_queue(sel_queue), .sel_valid(sel_valid)
   );

   // {nonempty[3:0], grant, expected valid, expected queue[1:0]}, from slot 0
   localparam logic [7:0] VEC [12] = '{
      8'hFF, 8'hF6, 8'hFE, 8'h7D, 8'h7E, 8'h1C,
      8'h1C, 8'h08, 8'h8F, 8'h2D, 8'h2D, 8'hFF };

   task automatic check_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one cycle, check the presented choice at the falling edge
   task automatic step(input string req, input logic [3:0] ne, input logic gr,
                       input logic ev, input int eq);
      q_nonempty = ne;
      grant_req  = gr;
      @(negedge clk);
      check_eq({req, " valid"}, int'(sel_valid), int'(ev));
      if (ev) check_eq({req, " queue"}, int'(sel_queue), eq);
      @(posedge clk); #1;
      grant_req = 1'b0;
   endtask

   task automatic tbl_write(input logic [15:0] w);
      tbl_wr_en = 1'b1;
      tbl_wr_word = w;
      @(posedge clk); #1;
      tbl_wr_en = 1'b0;
   endtask

   task automatic len_write(input logic [7:0] v);
      len_wr_en = 1'b1;
      len_wr_val = v;
      @(posedge clk); #1;
      len_wr_en = 1'b0;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      int pat [15] = '{3,2,3,1,3,2,3,0,3,2,3,1,3,2,3};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 / R6: reset state
      @(negedge clk);
      check_eq("R1 busy after reset", int'(tbl_busy), 0);
      check_eq("R6 no queue non-empty", int'(sel_valid), 0);
      @(posedge clk); #1;

      // R1: two laps of the reset pattern
      for (int i = 0; i < 30; i++) step("R1 default order", 4'hF, 1'b1, 1'b1, pat[i % 15]);

      // R5 / R6 / R7: vector walk starting at slot 0
      for (int v = 0; v < 12; v++)
         step("R5 R6 R7 vector", VEC[v][7:4], VEC[v][3], VEC[v][2], int'(VEC[v][1:0]));

      // R2 / R3: load group 0 with 0,1,2,3, then a write during busy
      tbl_write(16'h80E4);
      check_eq("R3 busy after write", int'(tbl_busy), 1);
      tbl_write(16'h80FF);           // ignored: busy
      check_eq("R3 busy cleared", int'(tbl_busy), 0);
      len_write(8'd4);               // R4
      step("R2 slot 0", 4'hF, 1'b1, 1'b1, 0);
      step("R2 slot 1", 4'hF, 1'b1, 1'b1, 1);
      step("R3 slot 2 kept", 4'hF, 1'b1, 1'b1, 2);
      step("R2 slot 3", 4'hF, 1'b1, 1'b1, 3);
      step("R4 wrap at 4", 4'hF, 1'b1, 1'b1, 0);
      step("R4 after wrap", 4'hF, 1'b1, 1'b1, 1);

      // R2: flag clear -> ignored, pointer untouched
      tbl_write(16'h001B);
      check_eq("R2 no busy without flag", int'(tbl_busy), 0);
      step("R2 flagless ignored", 4'hF, 1'b1, 1'b1, 2);

      // R8: accepted write clears pointer (pointer was at 3)
      tbl_write(16'h81FF);           // group 1 -> slots 4..7 = 3
      step("R8 pointer cleared", 4'hF, 1'b1, 1'b1, 0);
      len_write(8'd8);
      begin
         int exp8 [9] = '{0,1,2,3,3,3,3,3,0};
         for (int i = 0; i < 9; i++) step("R4 length 8", 4'hF, 1'b1, 1'b1, exp8[i]);
      end
      // R4: zero length ignored, pointer keeps its place (slot 1)
      len_write(8'd0);
      begin
         int exp0 [8] = '{1,2,3,3,3,3,3,0};
         for (int i = 0; i < 8; i++) step("R4 zero length ignored", 4'hF, 1'b1, 1'b1, exp0[i]);
      end

      // R4 / R5: full length, slot 127 reached
      tbl_write(16'h9FAA);           // group 31 -> slots 124..127 = 2
      len_write(8'd128);
      for (int i = 0; i < 6; i++) step("R5 only queue 2", 4'b0100, 1'b1, 1'b1, 2);
      step("R4 slot 127 used", 4'b0101, 1'b1, 1'b1, 2);
      step("R4 wrap from 127", 4'hF, 1'b1, 1'b1, 0);

      // R8: write and grant in the same cycle -> pointer to 0
      q_nonempty = 4'hF;
      grant_req = 1'b1;
      tbl_write(16'h80E4);
      grant_req = 1'b0;
      step("R8 write beats grant", 4'hF, 1'b1, 1'b1, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule